// File: doc/BRIEF.md
# Byte-Addressed Data Memory Controller

This block is a small synchronous data memory organised as 32-bit words but addressed in bytes. The caller gives a 32-bit byte address, 32-bit store data, an enable and a 2-bit operation code. The code selects one of four operations: a full-word read, a byte store, a halfword store or a word store. The block splits the byte address into a word index and a byte offset. From these it builds a per-lane write mask and moves the low-order store data into the addressed lane or lanes.

Accesses that break the alignment rule for their width are refused. A refused access writes nothing, raises a combinational misalignment indication for that cycle, and sets an error flag that stays set until reset. Loaded words come back unextended. Any narrowing or extension is left to the consumer.

Top module: `dmem_lane_ctrl`

## Requirements
- R1: After reset every word of the array reads as 0 and `err_flag` is 0.
- R2: With `en`=1 and `op`=2'b00, `rdata` equals, in the same cycle, the word at index `addr[IW+1:2]`, where IW = log2(DEPTH). In every other case `rdata` is 0.
- R3: With `en`=1 and `op`=2'b01, a byte store writes `wdata[7:0]` into lane `addr[1:0]`. Lanes are little-endian: lane 0 is bits [7:0] and lane 3 is bits [31:24]. The other three lanes keep their contents.
- R4: With `en`=1 and `op`=2'b10, a halfword store writes `wdata[15:0]` into bits [15:0] when `addr[1]`=0, or into bits [31:16] when `addr[1]`=1. The other half keeps its contents.
- R5: With `en`=1 and `op`=2'b11, a word store replaces the whole word with `wdata` on the rising clock edge.
- R6: With `en`=0 nothing is written, `misalign` is 0 and `err_flag` does not change.
- R7: `misalign` is 1 in three cases: an enabled `op` 2'b00 or 2'b11 with `addr[1:0]`≠0, or an enabled `op` 2'b10 with `addr[0]`=1. A byte store is never misaligned.
- R8: A misaligned store leaves the array unchanged.
- R9: `err_flag` becomes 1 on the clock edge that ends a cycle with `misalign`=1. It then stays 1 until reset.
- R10: A misaligned read still returns the aligned word that contains the addressed byte.
- R11: Address bits above `addr[IW+1]` are ignored, so the word index wraps modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores and the flag update on the rising edge |
| rst_n | input | 1 | Active-low reset; clears the array and the flag |
| en | input | 1 | Access enable |
| op | input | 2 | 00 word read, 01 byte store, 10 halfword store, 11 word store |
| addr | input | AW | Byte address |
| wdata | input | 32 | Store data, low-aligned |
| rdata | output | 32 | Read word, 0 unless reading |
| misalign | output | 1 | Current access violates its alignment |
| err_flag | output | 1 | Sticky misalignment error |

## Verification
A wrong lane mask or a wrong steering choice corrupts neighbouring bytes. That corruption is invisible until the word is read back, so every store is followed by a read of the same word in the next cycle or soon after. A misaligned store that is wrongly accepted shows up the same way, as a changed word on the next read. A flag that fails to latch or clears by itself differs at the port one cycle after the offending access, and this is checked on every vector. Aliased indices only show when a wrapped address is read back against the word it should overwrite.

// File: rtl/dmem_lane_ctrl.sv
module dmem_lane_ctrl #(
  parameter int AW    = 32,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          misalign,
  output logic          err_flag
);
  localparam int IW = $clog2(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [1:0]    ofs;
  logic [IW-1:0] idx;
  logic [3:0]    lane_en;
  logic [31:0]   steered;
  logic          wr_ok;

  assign ofs = addr[1:0];
  assign idx = addr[IW+1:2];

  always_comb begin
    misalign = 1'b0;
    if (en) begin
      case (op)
        2'b00, 2'b11: misalign = (ofs != 2'b00);
        2'b10:        misalign = ofs[0];
        default:      misalign = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (op)
      2'b01:   begin lane_en = 4'b0001 << ofs;                 steered = {4{wdata[7:0]}};  end
      2'b10:   begin lane_en = ofs[1] ? 4'b1100 : 4'b0011;     steered = {2{wdata[15:0]}}; end
      2'b11:   begin lane_en = 4'b1111;                        steered = wdata;            end
      default: begin lane_en = 4'b0000;                        steered = wdata;            end
    endcase
  end

  assign wr_ok = en && (op != 2'b00) && !misalign;
  assign rdata = (en && op == 2'b00) ? mem[idx] : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (wr_ok) begin
      for (int b = 0; b < 4; b++)
        if (lane_en[b]) mem[idx][8*b +: 8] <= steered[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_flag <= 1'b0;
    else if (misalign) err_flag <= 1'b1;
  end
endmodule

// File: rtl/dmem_lane_ctrl_chk.sv
module dmem_lane_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic [1:0]  op,
  input logic [31:0] rdata,
  input logic        misalign,
  input logic        err_flag
);
  AST_ERR_HOLDS:     assert property (@(posedge clk) disable iff (!rst_n) err_flag |=> err_flag);                    // R9
  AST_ERR_SETS:      assert property (@(posedge clk) disable iff (!rst_n) misalign |=> err_flag);                    // R9
  AST_ERR_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) (!err_flag && !misalign) |=> !err_flag);   // R6
  AST_RDATA_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) !(en && op == 2'b00) |-> rdata == 32'd0);  // R2
  AST_BYTE_ALIGNED:  assert property (@(posedge clk) disable iff (!rst_n) (op == 2'b01) |-> !misalign);              // R7
  AST_MIS_NEEDS_EN:  assert property (@(posedge clk) disable iff (!rst_n) !en |-> !misalign);                        // R6
endmodule

bind dmem_lane_ctrl dmem_lane_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op),
  .rdata(rdata), .misalign(misalign), .err_flag(err_flag)
);

// File: tb/dmem_lane_ctrl_test.sv
module dmem_lane_ctrl_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        misalign;
  logic        err_flag;

  dmem_lane_ctrl #(.AW(32), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .addr(addr),
    .wdata(wdata), .rdata(rdata), .misalign(misalign), .err_flag(err_flag)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] rd;
    logic        mis;
    logic        err;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] model [DEPTH];
  logic        model_err;
  int          applied = 0;
  int          bad = 0;
  bit          done = 0;

  function automatic logic is_mis(logic e, logic [1:0] o, logic [31:0] a);
    if (!e) return 1'b0;
    if (o == 2'b00 || o == 2'b11) return a[1:0] != 2'b00;
    if (o == 2'b10) return a[0];
    return 1'b0;
  endfunction

  task automatic access(input logic e, input logic [1:0] o, input logic [31:0] a,
                        input logic [31:0] d, input string tag);
    exp_t it;
    int   ix;
    logic m;
    @(negedge clk);
    ix = int'(a[7:2]) % DEPTH;
    m  = is_mis(e, o, a);
    it.rd  = (e && o == 2'b00) ? model[ix] : 32'd0;
    it.mis = m;
    it.err = model_err;
    it.tag = tag;
    sb.push_back(it);
    en = e; op = o; addr = a; wdata = d;
    if (e && o != 2'b00 && !m) begin
      case (o)
        2'b01: model[ix][8*a[1:0] +: 8] = d[7:0];
        2'b10: model[ix][16*a[1] +: 16] = d[15:0];
        default: model[ix] = d;
      endcase
    end
    if (m) model_err = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    en = 1'b0;
    rst_n = 1'b0;
    for (int w = 0; w < DEPTH; w++) model[w] = '0;
    model_err = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        applied++;
        if (rdata !== it.rd || misalign !== it.mis || err_flag !== it.err) begin
          bad++;
          $display("FAIL %s: rdata=%h mis=%b err=%b expected rdata=%h mis=%b err=%b",
                   it.tag, rdata, misalign, err_flag, it.rd, it.mis, it.err);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin : driver
    do_reset();
    access(1, 2'b00, 32'h0000_0000, 0, "R1 reset word0");
    access(1, 2'b00, 32'h0000_00FC, 0, "R1 reset last word");
    access(1, 2'b11, 32'h0000_0004, 32'hAABB_CCDD, "R5 word store");
    access(1, 2'b00, 32'h0000_0004, 0, "R5 word readback");
    access(1, 2'b01, 32'h0000_0005, 32'h1234_5677, "R3 byte lane1");
    access(1, 2'b00, 32'h0000_0004, 0, "R3 lane1 readback");
    access(1, 2'b01, 32'h0000_0007, 32'h0000_00EE, "R3 byte lane3");
    access(1, 2'b01, 32'h0000_0004, 32'hFFFF_FF01, "R3 byte lane0");
    access(1, 2'b00, 32'h0000_0004, 0, "R3 lanes readback");
    access(1, 2'b11, 32'h0000_0008, 32'h1111_2222, "R5 word store2");
    access(1, 2'b10, 32'h0000_000A, 32'hFFFF_5A5A, "R4 upper half");
    access(1, 2'b00, 32'h0000_0008, 0, "R4 upper readback");
    access(1, 2'b10, 32'h0000_0008, 32'h0000_C3C3, "R4 lower half");
    access(1, 2'b00, 32'h0000_0008, 0, "R4 lower readback");
    access(0, 2'b11, 32'h0000_0008, 32'hDEAD_BEEF, "R6 disabled store");
    access(0, 2'b00, 32'h0000_0008, 0, "R6 disabled read");
    access(1, 2'b00, 32'h0000_0008, 0, "R6 unchanged readback");
    access(0, 2'b11, 32'h0000_0003, 0, "R6 disabled misaligned");
    access(1, 2'b00, 32'h0000_0000, 0, "R6 flag still clear");
    access(1, 2'b11, 32'h0000_000D, 32'hCAFE_F00D, "R7 misaligned word store");
    access(1, 2'b00, 32'h0000_000C, 0, "R8 word not written, R9 flag set");
    access(1, 2'b10, 32'h0000_0009, 32'h0000_BEEF, "R7 misaligned half");
    access(1, 2'b00, 32'h0000_0008, 0, "R8 half not written");
    access(1, 2'b00, 32'h0000_0006, 0, "R10 misaligned read");
    access(1, 2'b01, 32'h0000_0003, 32'h0000_0099, "R7 byte never misaligned");
    access(1, 2'b00, 32'h0000_0000, 0, "R3 lane3 word0");
    access(1, 2'b11, 32'h0000_0100, 32'h5555_AAAA, "R11 wrapped store");
    access(1, 2'b00, 32'h0000_0000, 0, "R11 wrap readback");
    access(1, 2'b00, 32'h8000_0004, 0, "R11 high bits ignored");
    access(0, 2'b00, 32'h0000_0000, 0, "R9 flag held idle");
    do_reset();
    access(1, 2'b00, 32'h0000_0004, 0, "R1 second reset clears");
    access(1, 2'b11, 32'h0000_0010, 32'h0BAD_F00D, "R9 flag cleared by reset");
    access(1, 2'b00, 32'h0000_0010, 0, "R2 final read");
    repeat (3) @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule